// File: doc/BRIEF.md
# Register Rename and Result Status Table

This block is the rename table for a small floating-point register file in an out-of-order issue scheme. It holds two things for each architectural register. The first is the tag of the station that will produce the register's next value, or a blank if nothing is in flight. The second is the last value written back to that register.

When an instruction issues, two source lookups run combinationally. Each lookup returns a ready value if the register is blank, or the producer tag if it is not. At the next clock edge the destination is renamed to the issuing station's tag. This rename happens even when an older instruction still reads or writes that register, so write-after-read and write-after-write hazards never stall issue.

The block also watches the shared result bus. A broadcast updates a register only while its tag is still the latest writer of that register. A result that arrives in the same cycle as a lookup is forwarded to that lookup.

Top module: `rrs_table`

## Requirements
- R1: Reset (rstN low) blanks every status entry and zeroes every stored value, so after reset each lookup returns tag 0 and value 0.
- R2: Tag code 0 means blank. A lookup of a blank register returns tag 0 and the stored value.
- R3: A lookup of a register with a pending producer (nonzero tag) returns that tag and a value of 0, unless R8 applies.
- R4: An issue with issueValid high and a nonzero issueTag sets the status of issueDst to issueTag, visible from the next cycle. This happens even when that register already has a pending producer.
- R5: A broadcast (busValid high, nonzero busTag) whose tag equals a register's stored tag writes busData into that register and blanks its status from the next cycle.
- R6: A broadcast whose tag differs from a register's stored tag leaves that register's status and value unchanged. This covers results from older writers that have since been renamed away.
- R7: When an issue renames a register in the same cycle that a matching broadcast arrives for it, the register ends up holding the new issue tag.
- R8: A lookup of a register whose stored tag equals the tag on a valid broadcast in the same cycle returns tag 0 and busData.
- R9: An issue with issueValid low or issueTag 0 changes no entry, and a broadcast with busTag 0 changes no entry.
- R10: Both source lookups work independently and see the state before the current cycle's rename. An instruction that reads its own destination therefore gets the older producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction issues this cycle |
| issueDst | input | 2 | Destination register index |
| issueTag | input | TagW (4) | Station tag of the issuing instruction, 1..15 |
| srcAIdx | input | 2 | Index of the first source register |
| srcBIdx | input | 2 | Index of the second source register |
| srcAValue | output | DataW (64) | First source value when ready, else 0 |
| srcATag | output | TagW (4) | First source producer tag, 0 when ready |
| srcBValue | output | DataW (64) | Second source value when ready, else 0 |
| srcBTag | output | TagW (4) | Second source producer tag, 0 when ready |
| busValid | input | 1 | Result bus carries a result this cycle |
| busTag | input | TagW (4) | Tag of the station that produced the result |
| busData | input | DataW (64) | Result value |

## Verification
The assertions check these properties on every cycle:
- a rename lands in the named entry;
- a matching broadcast captures its data and blanks the entry unless a rename overrides it;
- an entry touched by neither a rename nor a broadcast stays put;
- no lookup ever reports the tag that is on the bus;
- a pending lookup carries a zero value.

The directed bench scenarios are the only way to show the ordered stories. These are:
- a write-after-write rename that makes an older result stale;
- the collision between a rename and a capture;
- the values seen after reset.

The random traffic, biased so that broadcasts often hit live tags, compares every lookup against a reference model.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int REG_CNT = 4;
  localparam int IDX_W   = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;
  localparam int SRC_CNT = 2;

  // strobes from control to datapath, one bit per architectural register
  typedef struct packed {
    logic [REG_CNT-1:0] rename;   // load the issue tag
    logic [REG_CNT-1:0] capture;  // load the bus data
    logic [REG_CNT-1:0] clear;    // blank the status
  } rrsStrobe_t;
endpackage

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
#(
  parameter int TagW = 4
) (
  input  logic                          issueValid,
  input  logic [IDX_W-1:0]              issueDst,
  input  logic [TagW-1:0]               issueTag,
  input  logic                          busValid,
  input  logic [TagW-1:0]               busTag,
  input  logic [REG_CNT-1:0][TagW-1:0]  tagQ,
  output rrsStrobe_t                    strobe
);
  logic issueLive;
  logic busLive;

  assign issueLive = issueValid && (issueTag != '0);
  assign busLive   = busValid && (busTag != '0);

  for (genvar r = 0; r < REG_CNT; r++) begin : gReg
    logic renameHit;
    logic busHit;
    assign renameHit = issueLive && (issueDst == IDX_W'(r));
    assign busHit    = busLive && (tagQ[r] == busTag);
    assign strobe.rename[r]  = renameHit;
    assign strobe.capture[r] = busHit;
    // a fresh rename outranks the completion of the previous writer
    assign strobe.clear[r]   = busHit && !renameHit;
  end
endmodule

// File: rtl/rrs_data.sv
module rrs_data
  import rrs_pkg::*;
#(
  parameter int TagW  = 4,
  parameter int DataW = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rrsStrobe_t                    strobe,
  input  logic [TagW-1:0]               issueTag,
  input  logic                          busValid,
  input  logic [TagW-1:0]               busTag,
  input  logic [DataW-1:0]              busData,
  input  logic [SRC_CNT-1:0][IDX_W-1:0] srcIdx,
  output logic [SRC_CNT-1:0][DataW-1:0] srcValue,
  output logic [SRC_CNT-1:0][TagW-1:0]  srcTag,
  output logic [REG_CNT-1:0][TagW-1:0]  tagQ,
  output logic [REG_CNT-1:0][DataW-1:0] valQ
);
  for (genvar r = 0; r < REG_CNT; r++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ[r] <= '0;
        valQ[r] <= '0;
      end else begin
        if (strobe.rename[r]) begin
          tagQ[r] <= issueTag;
        end else if (strobe.clear[r]) begin
          tagQ[r] <= '0;
        end
        if (strobe.capture[r]) begin
          valQ[r] <= busData;
        end
      end
    end
  end

  for (genvar s = 0; s < SRC_CNT; s++) begin : gPort
    logic [TagW-1:0]  curTag;
    logic [DataW-1:0] curVal;
    logic             fwdHit;
    assign curTag = tagQ[srcIdx[s]];
    assign curVal = valQ[srcIdx[s]];
    assign fwdHit = busValid && (curTag != '0) && (busTag == curTag);
    always_comb begin
      if (fwdHit) begin
        srcTag[s]   = '0;
        srcValue[s] = busData;
      end else if (curTag != '0) begin
        srcTag[s]   = curTag;
        srcValue[s] = '0;
      end else begin
        srcTag[s]   = '0;
        srcValue[s] = curVal;
      end
    end
  end
endmodule

// File: rtl/rrs_table.sv
module rrs_table
  import rrs_pkg::*;
#(
  parameter int TagW  = 4,
  parameter int DataW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [TagW-1:0]   issueTag,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic [DataW-1:0]  srcAValue,
  output logic [TagW-1:0]   srcATag,
  output logic [DataW-1:0]  srcBValue,
  output logic [TagW-1:0]   srcBTag,
  input  logic              busValid,
  input  logic [TagW-1:0]   busTag,
  input  logic [DataW-1:0]  busData
);
  rrsStrobe_t                    strobe;
  logic [REG_CNT-1:0][TagW-1:0]  tagQ;
  logic [REG_CNT-1:0][DataW-1:0] valQ;
  logic [SRC_CNT-1:0][IDX_W-1:0] srcIdx;
  logic [SRC_CNT-1:0][DataW-1:0] srcValue;
  logic [SRC_CNT-1:0][TagW-1:0]  srcTag;

  assign srcIdx    = {srcBIdx, srcAIdx};
  assign srcAValue = srcValue[0];
  assign srcBValue = srcValue[1];
  assign srcATag   = srcTag[0];
  assign srcBTag   = srcTag[1];

  rrs_ctrl #(.TagW(TagW)) uCtrl (
    .issueValid (issueValid),
    .issueDst   (issueDst),
    .issueTag   (issueTag),
    .busValid   (busValid),
    .busTag     (busTag),
    .tagQ       (tagQ),
    .strobe     (strobe)
  );

  rrs_data #(.TagW(TagW), .DataW(DataW)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .issueTag (issueTag),
    .busValid (busValid),
    .busTag   (busTag),
    .busData  (busData),
    .srcIdx   (srcIdx),
    .srcValue (srcValue),
    .srcTag   (srcTag),
    .tagQ     (tagQ),
    .valQ     (valQ)
  );
endmodule

// File: rtl/rrs_check.sv
module rrs_check
  import rrs_pkg::*;
#(
  parameter int TagW  = 4,
  parameter int DataW = 64
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          issueValid,
  input logic [IDX_W-1:0]              issueDst,
  input logic [TagW-1:0]               issueTag,
  input logic [TagW-1:0]               srcATag,
  input logic [DataW-1:0]              srcAValue,
  input logic [TagW-1:0]               srcBTag,
  input logic [DataW-1:0]              srcBValue,
  input logic                          busValid,
  input logic [TagW-1:0]               busTag,
  input logic [DataW-1:0]              busData,
  input logic [REG_CNT-1:0][TagW-1:0]  tagQ,
  input logic [REG_CNT-1:0][DataW-1:0] valQ
);
  logic issueLive;
  logic busLive;
  assign issueLive = issueValid && (issueTag != '0);
  assign busLive   = busValid && (busTag != '0);

  // R4: an issue lands its tag in the destination entry
  p_rename_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && issueLive) |-> tagQ[$past(issueDst)] == $past(issueTag));

  // R8: a lookup never reports the tag that is on the bus
  p_bypass_a_r8: assert property (@(posedge clk) disable iff (!rstN)
    busLive |-> (srcATag != busTag) && (srcBTag != busTag));

  // R3: a pending lookup carries no value
  p_pending_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((srcATag != '0) |-> (srcAValue == '0)) and ((srcBTag != '0) |-> (srcBValue == '0)));

  for (genvar r = 0; r < REG_CNT; r++) begin : gReg
    // R5: matching result captured and the entry blanked
    p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN && busLive && tagQ[r] == busTag && !(issueLive && issueDst == IDX_W'(r)))
        |-> (tagQ[r] == '0) && (valQ[r] == $past(busData)));

    // R6 and R9: untouched entries hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN && !(busLive && tagQ[r] == busTag) && !(issueLive && issueDst == IDX_W'(r)))
        |-> (tagQ[r] == $past(tagQ[r])) && (valQ[r] == $past(valQ[r])));

    // R7: rename wins over a same-cycle capture
    p_rename_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN && busLive && tagQ[r] == busTag && issueLive && issueDst == IDX_W'(r))
        |-> tagQ[r] == $past(issueTag));
  end
endmodule

bind rrs_table rrs_check #(.TagW(TagW), .DataW(DataW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueDst   (issueDst),
  .issueTag   (issueTag),
  .srcATag    (srcATag),
  .srcAValue  (srcAValue),
  .srcBTag    (srcBTag),
  .srcBValue  (srcBValue),
  .busValid   (busValid),
  .busTag     (busTag),
  .busData    (busData),
  .tagQ       (tagQ),
  .valQ       (valQ)
);

// File: tb/tb_rrs_table.sv
`timescale 1ns/1ps
module tb_rrs_table;
  localparam int TagW  = 4;
  localparam int DataW = 64;
  localparam int NREG  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             issueValid = 1'b0;
  logic [1:0]       issueDst = '0;
  logic [TagW-1:0]  issueTag = '0;
  logic [1:0]       srcAIdx = '0;
  logic [1:0]       srcBIdx = '0;
  logic [DataW-1:0] srcAValue, srcBValue;
  logic [TagW-1:0]  srcATag, srcBTag;
  logic             busValid = 1'b0;
  logic [TagW-1:0]  busTag = '0;
  logic [DataW-1:0] busData = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [TagW-1:0]  refTag [NREG];
  logic [DataW-1:0] refVal [NREG];

  always #2 clk = ~clk;

  rrs_table #(.TagW(TagW), .DataW(DataW)) dut (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueDst(issueDst), .issueTag(issueTag),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAValue(srcAValue), .srcATag(srcATag),
    .srcBValue(srcBValue), .srcBTag(srcBTag),
    .busValid(busValid), .busTag(busTag), .busData(busData)
  );

  function automatic logic [TagW-1:0] expTag(input int idx);
    if (refTag[idx] != '0 && busValid && busTag == refTag[idx]) return '0;
    return refTag[idx];
  endfunction

  function automatic logic [DataW-1:0] expVal(input int idx);
    if (refTag[idx] != '0 && busValid && busTag == refTag[idx]) return busData;
    if (refTag[idx] != '0) return '0;
    return refVal[idx];
  endfunction

  function automatic string autoReq(input int idx);
    if (refTag[idx] != '0 && busValid && busTag == refTag[idx]) return "R8";
    if (refTag[idx] != '0) return "R3";
    return "R2";
  endfunction

  task automatic checkPort(input string port, input logic [TagW-1:0] gotT,
                           input logic [DataW-1:0] gotV, input int idx, input string req);
    string r;
    r = (req == "") ? autoReq(idx) : req;
    checks++;
    if (gotT !== expTag(idx) || gotV !== expVal(idx)) begin
      errors++;
      $display("FAIL %s port %s reg %0d: tag=%0d value=%h expected tag=%0d value=%h",
               r, port, idx, gotT, gotV, expTag(idx), expVal(idx));
    end
  endtask

  task automatic modelEdge();
    for (int r = 0; r < NREG; r++) begin
      if (busValid && busTag != '0 && refTag[r] == busTag) begin
        refVal[r] = busData;
        refTag[r] = '0;
      end
      if (issueValid && issueTag != '0 && issueDst == 2'(r)) refTag[r] = issueTag;
    end
  endtask

  // drive at the falling edge, compare 1 ns later, then advance the model at the rising edge
  task automatic step(input logic iv, input logic [1:0] d, input logic [TagW-1:0] t,
                      input logic bv, input logic [TagW-1:0] bt, input logic [DataW-1:0] bd,
                      input logic [1:0] a, input logic [1:0] b, input string req);
    issueValid = iv; issueDst = d; issueTag = t;
    busValid = bv; busTag = bt; busData = bd;
    srcAIdx = a; srcBIdx = b;
    #1;
    checkPort("A", srcATag, srcAValue, int'(a), req);
    checkPort("B", srcBTag, srcBValue, int'(b), req);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NREG; r++) begin
      refTag[r] = '0;
      refVal[r] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: every entry blank and zero after reset
    step(0, 0, 0, 0, 0, 0, 2'd0, 2'd1, "R1");
    step(0, 0, 0, 0, 0, 0, 2'd2, 2'd3, "R1");

    // R4 and R10: rename, then a write-after-write rename that reads its own destination
    step(1, 2'd1, 4'd3, 0, 0, 0, 2'd1, 2'd0, "R10");
    step(1, 2'd1, 4'd5, 0, 0, 0, 2'd1, 2'd1, "R4");
    step(0, 0, 0, 0, 0, 0, 2'd1, 2'd0, "R4");

    // R6: a stale result from tag 3 must not touch register 1
    step(0, 0, 0, 1, 4'd3, 64'hDEAD_0000_0000_0003, 2'd1, 2'd1, "R6");
    step(0, 0, 0, 0, 0, 0, 2'd1, 2'd2, "R6");

    // R5: the live writer completes
    step(0, 0, 0, 1, 4'd5, 64'h1111_2222_3333_4444, 2'd2, 2'd3, "R5");
    step(0, 0, 0, 0, 0, 0, 2'd1, 2'd1, "R5");

    // R8: same-cycle forwarding, then the stored value
    step(1, 2'd2, 4'd7, 0, 0, 0, 2'd0, 2'd3, "R2");
    step(0, 0, 0, 1, 4'd7, 64'h0A0B_0C0D_0E0F_1011, 2'd2, 2'd2, "R8");
    step(0, 0, 0, 0, 0, 0, 2'd2, 2'd1, "R5");

    // R7: a rename collides with completion of the previous writer
    step(1, 2'd0, 4'd9, 0, 0, 0, 2'd3, 2'd3, "R2");
    step(1, 2'd0, 4'd10, 1, 4'd9, 64'h5555_AAAA_5555_AAAA, 2'd1, 2'd2, "R2");
    step(0, 0, 0, 0, 0, 0, 2'd0, 2'd0, "R7");

    // R9: no-effect issues and a zero-tag broadcast
    step(0, 2'd3, 4'd4, 0, 0, 0, 2'd3, 2'd3, "R9");
    step(1, 2'd3, 4'd0, 0, 0, 0, 2'd3, 2'd3, "R9");
    step(0, 0, 0, 1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd3, "R9");
    step(0, 0, 0, 0, 0, 0, 2'd3, 2'd2, "R9");

    // random traffic, broadcasts biased toward live tags
    for (int n = 0; n < 3000; n++) begin
      logic iv, bv;
      logic [1:0] d, a, b;
      logic [TagW-1:0] t, bt;
      logic [DataW-1:0] bd;
      iv = ($urandom % 3) != 0;
      d  = 2'($urandom);
      t  = (($urandom % 16) == 0) ? '0 : TagW'(1 + ($urandom % 15));
      bv = ($urandom % 2) == 1;
      bt = (($urandom % 4) != 0) ? refTag[$urandom % NREG] : TagW'($urandom);
      bd = {$urandom, $urandom};
      a  = 2'($urandom);
      b  = 2'($urandom);
      step(iv, d, t, bv, bt, bd, a, b, "");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule